// File: doc/BRIEF.md
# Adaptive Sine/Cosine Offset Tracker

This block takes two signed, digitised quadrature channels (a sine track and a cosine track) on every clock. It learns the DC offset of each channel while the inputs move, and subtracts that offset from each channel. The result is a pair of offset-free samples that can go to an angle or interpolation stage. No separate calibration pass is needed. Because the estimate keeps adapting, slow drift such as the effect of temperature on the sensor or the amplifier is followed automatically.

The estimate is the midpoint between the largest and the smallest sample that each channel reaches during one signal period. The block detects periods by following the signal vector through the four sign quadrants. It moves each correction a fixed fraction of the way toward the new midpoint, but only when the period just finished and the one before it were both complete turns in the same direction. It also skips the update when the period was shorter than a clock-count limit. Back-and-forth motion within about two periods, vibration, and rotation that is too fast for reliable extrema therefore leave the estimate untouched. Each correction saturates at a fixed bound.

Top module: `sct_offset_tracker`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `off_sin`, `off_cos`, `upd_o`, `sin_out` and `cos_out` are all zero.
- R2: On every clock edge, `sin_out` and `cos_out` register the sign-extended input sample minus the correction shown on `off_sin`/`off_cos` before that edge. The latency is one cycle and the output is DATA_W+1 bits wide.
- R3: Quadrants are taken from the raw input signs, where zero counts as non-negative. Q0 is sin≥0 with cos≥0, Q1 is sin≥0 with cos<0, Q2 is both negative, and Q3 is sin<0 with cos≥0. Forward rotation steps Q0→Q1→Q2→Q3→Q0 and reverse rotation steps the other way. Both directions are tracked, and a period ends on each step into Q0.
- R4: A correction update happens only at a period end where the four steps of the period just finished, and the four steps of the period before it, all went in one direction. A reversal or a diagonal quadrant jump discards both periods.
- R5: No update happens at the end of a period lasting fewer than MIN_PERIOD clocks (default 20000). The period length is counted from one step into Q0 to the next.
- R6: On an update, each channel computes center = floor((max+min)/2) of its raw samples over the period, boundary samples included. The correction then becomes off + floor((center − off) / 2^STEP_SHIFT), with STEP_SHIFT defaulting to 3.
- R7: Each correction saturates to the range −OFF_LIM…+OFF_LIM and never wraps.
- R8: The two channels are corrected independently. For offsets within the correction range and smaller than the signal amplitude, each correction settles within 10 LSB of the true offset in at most 160 periods, in either direction of rotation.
- R9: A frequency that rises or falls monotonically over many periods, with every period above MIN_PERIOD, does not prevent convergence.
- R10: `upd_o` is a one-cycle pulse in the first cycle that shows the new corrections. Both corrections are otherwise constant, and two pulses are at least MIN_PERIOD cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one sample pair per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| sin_in | input | DATA_W | Signed raw sine-track sample |
| cos_in | input | DATA_W | Signed raw cosine-track sample |
| sin_out | output | DATA_W+1 | Offset-corrected sine sample, registered |
| cos_out | output | DATA_W+1 | Offset-corrected cosine sample, registered |
| off_sin | output | DATA_W | Current sine-track correction |
| off_cos | output | DATA_W | Current cosine-track correction |
| upd_o | output | 1 | Pulse marking a new correction pair |

## Verification
The assertions assume that the input vector moves through neighbouring quadrants and that no period shorter than MIN_PERIOD produces a qualified end. Under these assumptions, updates are spaced by at least one full period and arrive one at a time. The stimulus keeps this true: it builds every sample from a sinusoid whose amplitude (800) is larger than any applied offset. It advances the phase by at most 1/64 of a turn per clock, so quadrant steps are never diagonal. It reverses direction only between samples, never inside one. The sweep covers both rotation directions, a set of offset pairs, a chirp, a too-fast rotation, short oscillation and saturation.

// File: rtl/sct_pkg.sv
package sct_pkg;

    typedef enum logic [1:0] {
        DIR_NONE = 2'd0,
        DIR_FWD  = 2'd1,
        DIR_REV  = 2'd2
    } dir_e;

    // Sign quadrant in rotation order: 0 (+,+) 1 (cos-) 2 (both-) 3 (sin-)
    function automatic logic [1:0] quad_of(input logic sin_neg, input logic cos_neg);
        logic [1:0] q;
        if (!cos_neg) q = sin_neg ? 2'd3 : 2'd0;
        else          q = sin_neg ? 2'd2 : 2'd1;
        return q;
    endfunction

endpackage

// File: rtl/sct_period_qual.sv
module sct_period_qual
    import sct_pkg::*;
#(
    parameter int unsigned MIN_PERIOD = 20000
)(
    input  logic clk,
    input  logic rst_n,
    input  logic sin_neg,
    input  logic cos_neg,
    output logic wrap_o,
    output logic qual_o
);
    localparam int unsigned CNT_W = $clog2(MIN_PERIOD + 1);
    localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(MIN_PERIOD);

    typedef struct packed {
        logic             primed;
        logic [1:0]       quad;
        dir_e             dir;
        logic [2:0]       steps;
        logic             seg_ok;
        logic             prev_full;
        logic [CNT_W-1:0] per_cnt;
        logic             qual;
    } st_t;

    st_t        st_d, st_q;
    logic [1:0] q_new;
    logic       fwd, rev, same, full, long_ok, wrap;
    dir_e       step_dir;

    always_comb begin
        st_d      = st_q;
        st_d.qual = 1'b0;
        wrap      = 1'b0;
        full      = 1'b0;
        q_new     = quad_of(sin_neg, cos_neg);
        fwd       = (q_new == 2'(st_q.quad + 2'd1));
        rev       = (q_new == 2'(st_q.quad - 2'd1));
        step_dir  = fwd ? DIR_FWD : DIR_REV;
        same      = (step_dir == st_q.dir);
        long_ok   = (st_q.per_cnt >= CNT_LIM);

        if (st_q.per_cnt < CNT_LIM) st_d.per_cnt = st_q.per_cnt + 1'b1;

        if (!st_q.primed) begin
            st_d.primed = 1'b1;
            st_d.quad   = q_new;
        end else if (q_new != st_q.quad) begin
            st_d.quad = q_new;
            if (!fwd && !rev) begin
                // diagonal jump: direction unknown, drop history
                st_d.dir       = DIR_NONE;
                st_d.seg_ok    = 1'b0;
                st_d.prev_full = 1'b0;
                st_d.steps     = 3'd0;
            end else begin
                if (same) begin
                    st_d.steps = (st_q.steps == 3'd7) ? 3'd7 : st_q.steps + 3'd1;
                end else begin
                    st_d.dir       = step_dir;
                    st_d.seg_ok    = 1'b0;
                    st_d.prev_full = 1'b0;
                    st_d.steps     = 3'd1;
                end
                if (q_new == 2'd0) begin
                    wrap           = 1'b1;
                    full           = same && st_q.seg_ok && (st_q.steps == 3'd3);
                    st_d.qual      = full && st_q.prev_full && long_ok;
                    st_d.prev_full = full;
                    st_d.seg_ok    = 1'b1;
                    st_d.steps     = 3'd0;
                    st_d.per_cnt   = CNT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{primed: 1'b0, quad: 2'd0, dir: DIR_NONE, steps: 3'd0,
                      seg_ok: 1'b0, prev_full: 1'b0, per_cnt: '0, qual: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign wrap_o = wrap;
    assign qual_o = st_q.qual;

endmodule

// File: rtl/sct_extrema.sv
module sct_extrema #(
    parameter int unsigned DATA_W = 12
)(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [DATA_W-1:0] sample_i,
    input  logic                     wrap_i,
    output logic signed [DATA_W-1:0] lo_o,
    output logic signed [DATA_W-1:0] hi_o
);
    typedef struct packed {
        logic [DATA_W-1:0] run_lo;
        logic [DATA_W-1:0] run_hi;
        logic [DATA_W-1:0] lat_lo;
        logic [DATA_W-1:0] lat_hi;
    } st_t;

    st_t                     st_d, st_q;
    logic signed [DATA_W-1:0] cur_lo, cur_hi;

    always_comb begin
        st_d   = st_q;
        cur_lo = (sample_i < $signed(st_q.run_lo)) ? sample_i : $signed(st_q.run_lo);
        cur_hi = (sample_i > $signed(st_q.run_hi)) ? sample_i : $signed(st_q.run_hi);
        if (wrap_i) begin
            st_d.lat_lo = cur_lo;
            st_d.lat_hi = cur_hi;
            st_d.run_lo = sample_i;
            st_d.run_hi = sample_i;
        end else begin
            st_d.run_lo = cur_lo;
            st_d.run_hi = cur_hi;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lo_o = $signed(st_q.lat_lo);
    assign hi_o = $signed(st_q.lat_hi);

endmodule

// File: rtl/sct_offset_step.sv
module sct_offset_step #(
    parameter int unsigned DATA_W     = 12,
    parameter int unsigned OFF_LIM    = 1000,
    parameter int unsigned STEP_SHIFT = 3
)(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     qual_i,
    input  logic signed [DATA_W-1:0] lo_i,
    input  logic signed [DATA_W-1:0] hi_i,
    output logic signed [DATA_W-1:0] off_o
);
    localparam int unsigned EW = DATA_W + 2;
    localparam logic signed [EW-1:0] LIM_P = EW'(OFF_LIM);
    localparam logic signed [EW-1:0] LIM_N = -LIM_P;

    typedef struct packed {
        logic [DATA_W-1:0] off;
    } st_t;

    st_t                  st_d, st_q;
    logic signed [EW-1:0] lo_x, hi_x, off_x, center, err, nxt;

    always_comb begin
        st_d   = st_q;
        lo_x   = $signed({{2{lo_i[DATA_W-1]}}, lo_i});
        hi_x   = $signed({{2{hi_i[DATA_W-1]}}, hi_i});
        off_x  = $signed({{2{st_q.off[DATA_W-1]}}, st_q.off});
        center = (lo_x + hi_x) >>> 1;
        err    = center - off_x;
        nxt    = off_x + (err >>> STEP_SHIFT);
        if (qual_i) begin
            if (nxt > LIM_P)      st_d.off = LIM_P[DATA_W-1:0];
            else if (nxt < LIM_N) st_d.off = LIM_N[DATA_W-1:0];
            else                  st_d.off = nxt[DATA_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign off_o = $signed(st_q.off);

endmodule

// File: rtl/sct_offset_tracker.sv
module sct_offset_tracker #(
    parameter int unsigned DATA_W     = 12,
    parameter int unsigned OFF_LIM    = 1000,
    parameter int unsigned MIN_PERIOD = 20000,
    parameter int unsigned STEP_SHIFT = 3
)(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [DATA_W-1:0] sin_in,
    input  logic signed [DATA_W-1:0] cos_in,
    output logic signed [DATA_W:0]   sin_out,
    output logic signed [DATA_W:0]   cos_out,
    output logic signed [DATA_W-1:0] off_sin,
    output logic signed [DATA_W-1:0] off_cos,
    output logic                     upd_o
);
    localparam int unsigned N_CH = 2;

    typedef struct packed {
        logic [DATA_W:0] corr_s;
        logic [DATA_W:0] corr_c;
        logic            upd;
    } st_t;

    st_t                     st_d, st_q;
    logic                    wrap, qual;
    logic signed [DATA_W-1:0] raw_a [N_CH];
    logic signed [DATA_W-1:0] off_a [N_CH];
    logic signed [DATA_W-1:0] lo_a  [N_CH];
    logic signed [DATA_W-1:0] hi_a  [N_CH];

    assign raw_a[0] = sin_in;
    assign raw_a[1] = cos_in;

    sct_period_qual #(.MIN_PERIOD(MIN_PERIOD)) qual_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .sin_neg (sin_in[DATA_W-1]),
        .cos_neg (cos_in[DATA_W-1]),
        .wrap_o  (wrap),
        .qual_o  (qual)
    );

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        sct_extrema #(.DATA_W(DATA_W)) ext_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .sample_i (raw_a[ch]),
            .wrap_i   (wrap),
            .lo_o     (lo_a[ch]),
            .hi_o     (hi_a[ch])
        );
        sct_offset_step #(
            .DATA_W     (DATA_W),
            .OFF_LIM    (OFF_LIM),
            .STEP_SHIFT (STEP_SHIFT)
        ) step_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .qual_i (qual),
            .lo_i   (lo_a[ch]),
            .hi_i   (hi_a[ch]),
            .off_o  (off_a[ch])
        );
    end

    always_comb begin
        st_d        = st_q;
        st_d.corr_s = {sin_in[DATA_W-1], sin_in} - {off_a[0][DATA_W-1], off_a[0]};
        st_d.corr_c = {cos_in[DATA_W-1], cos_in} - {off_a[1][DATA_W-1], off_a[1]};
        st_d.upd    = qual;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sin_out = $signed(st_q.corr_s);
    assign cos_out = $signed(st_q.corr_c);
    assign off_sin = off_a[0];
    assign off_cos = off_a[1];
    assign upd_o   = st_q.upd;

endmodule

// File: rtl/sct_offset_tracker_chk.sv
module sct_offset_tracker_chk #(
    parameter int unsigned DATA_W     = 12,
    parameter int unsigned OFF_LIM    = 1000,
    parameter int unsigned MIN_PERIOD = 20000
)(
    input logic                     clk,
    input logic                     rst_n,
    input logic signed [DATA_W-1:0] off_sin,
    input logic signed [DATA_W-1:0] off_cos,
    input logic                     upd_o
);
    localparam int unsigned GW = $clog2(MIN_PERIOD + 1);
    localparam logic [GW-1:0] GAP_LIM = GW'(MIN_PERIOD);
    localparam int LIM = int'(OFF_LIM);

    logic          armed;
    logic [GW-1:0] gap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed <= 1'b0;
            gap   <= '0;
        end else begin
            armed <= 1'b1;
            if (upd_o)              gap <= GW'(1);
            else if (gap < GAP_LIM) gap <= gap + 1'b1;
        end
    end

    // R7: corrections stay inside the saturation range
    p_off_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(off_sin) <= LIM) && (int'(off_sin) >= -LIM) &&
        (int'(off_cos) <= LIM) && (int'(off_cos) >= -LIM));

    // R10: corrections only move together with the update pulse
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !upd_o) |-> ($stable(off_sin) && $stable(off_cos)));

    // R10: the update marker is a single-cycle pulse
    p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |=> !upd_o);

    // R5: updates are spaced by at least one minimum period
    p_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |-> (gap >= GAP_LIM));

endmodule

bind sct_offset_tracker sct_offset_tracker_chk #(
    .DATA_W     (DATA_W),
    .OFF_LIM    (OFF_LIM),
    .MIN_PERIOD (MIN_PERIOD)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .off_sin (off_sin),
    .off_cos (off_cos),
    .upd_o   (upd_o)
);

// File: tb/sct_offset_tracker_tb_top.sv
module sct_offset_tracker_tb_top;
    localparam int  CLK_PERIOD = 10;
    localparam int  DW   = 12;
    localparam int  LIM  = 300;
    localparam int  MINP = 100;
    localparam int  SH   = 3;
    localparam real PI   = 3.14159265358979;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic signed [DW-1:0] sin_in = '0;
    logic signed [DW-1:0] cos_in = '0;
    logic signed [DW:0]   sin_out, cos_out;
    logic signed [DW-1:0] off_sin, off_cos;
    logic                 upd_o;

    int  checks = 0, fails = 0;
    int  r2_bad = 0, r10_bad = 0, upd_seen = 0;
    int  exp_s = 0, exp_c = 0, last_os = 0, last_oc = 0;
    int  fu_s = 0, fu_c = 0;
    bit  fu_got = 1'b0, pend = 1'b0, mon = 1'b0;
    real ph = 0.0, amp = 800.0, os_r = 0.0, oc_r = 0.0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sct_offset_tracker #(
        .DATA_W(DW), .OFF_LIM(LIM), .MIN_PERIOD(MINP), .STEP_SHIFT(SH)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .sin_in(sin_in), .cos_in(cos_in),
        .sin_out(sin_out), .cos_out(cos_out),
        .off_sin(off_sin), .off_cos(off_cos), .upd_o(upd_o)
    );

    task automatic chk(input string req, input string what, input int act, input int expv, input bit ok);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // one clock: compare outputs with values predicted last cycle, then drive
    task automatic step(input real inc);
        @(negedge clk);
        if (mon) begin
            if (pend && (int'(sin_out) != exp_s || int'(cos_out) != exp_c)) r2_bad++;
            if (!upd_o && (int'(off_sin) != last_os || int'(off_cos) != last_oc)) r10_bad++;
            if (upd_o) begin
                upd_seen++;
                if (!fu_got) begin
                    fu_got = 1'b1;
                    fu_s = int'(off_sin);
                    fu_c = int'(off_cos);
                end
            end
        end
        last_os = int'(off_sin);
        last_oc = int'(off_cos);
        ph += inc;
        sin_in = DW'(int'(os_r + amp * $sin(2.0 * PI * ph)));
        cos_in = DW'(int'(oc_r + amp * $cos(2.0 * PI * ph)));
        exp_s  = int'(sin_in) - int'(off_sin);
        exp_c  = int'(cos_in) - int'(off_cos);
        pend   = mon;
    endtask

    task automatic move(input real p0, input real p1, input real nper, input real dirn);
        real done = 0.0;
        real p;
        while (done < nper) begin
            p = p0 + (p1 - p0) * done / nper;
            step(dirn / p);
            done += 1.0 / p;
        end
    endtask

    function automatic bit near(input int a, input int b);
        return (a - b <= 10) && (b - a <= 10);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog requirement=all actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int tgt_s [4] = '{250, -280, -60, 150};
        int tgt_c [4] = '{-200, 120, -290, 290};
        int a, b, u0;

        repeat (4) step(0.0);
        chk("R1", "off_sin in reset", int'(off_sin), 0, off_sin == 0);
        chk("R1", "off_cos in reset", int'(off_cos), 0, off_cos == 0);
        chk("R1", "upd_o in reset", int'(upd_o), 0, upd_o == 1'b0);
        chk("R1", "sin_out in reset", int'(sin_out), 0, sin_out == 0);
        rst_n = 1'b1;
        mon = 1'b1;

        // convergence sweep, alternating rotation direction
        for (int k = 0; k < 4; k++) begin
            os_r = real'(tgt_s[k]);
            oc_r = real'(tgt_c[k]);
            move(128.0, 128.0, 160.0, (k % 2 == 1) ? -1.0 : 1.0);
            if (k == 0) begin
                chk("R6", "first sin update", fu_s, 31, fu_got && fu_s == 31);
                chk("R6", "first cos update", fu_c, -25, fu_got && fu_c == -25);
            end
            if (k % 2 == 1) begin
                chk("R3", "reverse rotation sin settles", int'(off_sin), tgt_s[k], near(int'(off_sin), tgt_s[k]));
                chk("R3", "reverse rotation cos settles", int'(off_cos), tgt_c[k], near(int'(off_cos), tgt_c[k]));
            end else begin
                chk("R8", "sin settles", int'(off_sin), tgt_s[k], near(int'(off_sin), tgt_s[k]));
                chk("R8", "cos settles", int'(off_cos), tgt_c[k], near(int'(off_cos), tgt_c[k]));
            end
        end

        // monotonic deceleration-free chirp: period shrinks 200 -> 110 clocks
        os_r = -100.0;
        oc_r = 210.0;
        move(200.0, 110.0, 160.0, 1.0);
        chk("R9", "chirp sin settles", int'(off_sin), -100, near(int'(off_sin), -100));
        chk("R9", "chirp cos settles", int'(off_cos), 210, near(int'(off_cos), 210));

        // periods shorter than the minimum must not update
        os_r = 200.0;
        oc_r = -150.0;
        move(64.0, 64.0, 3.0, 1.0);
        a = int'(off_sin); b = int'(off_cos); u0 = upd_seen;
        move(64.0, 64.0, 20.0, 1.0);
        chk("R5", "fast sin unchanged", int'(off_sin), a, int'(off_sin) == a);
        chk("R5", "fast cos unchanged", int'(off_cos), b, int'(off_cos) == b);
        chk("R5", "fast update count", upd_seen - u0, 0, upd_seen == u0);

        // oscillation of 1.5 periods each way must not update
        a = int'(off_sin); b = int'(off_cos); u0 = upd_seen;
        for (int i = 0; i < 8; i++) move(128.0, 128.0, 1.5, (i % 2 == 0) ? -1.0 : 1.0);
        chk("R4", "vibration sin unchanged", int'(off_sin), a, int'(off_sin) == a);
        chk("R4", "vibration cos unchanged", int'(off_cos), b, int'(off_cos) == b);
        chk("R4", "vibration update count", upd_seen - u0, 0, upd_seen == u0);

        // offsets beyond the range saturate
        os_r = 500.0;
        oc_r = -450.0;
        move(128.0, 128.0, 160.0, 1.0);
        chk("R7", "sin saturates", int'(off_sin), LIM, int'(off_sin) == LIM);
        chk("R7", "cos saturates", int'(off_cos), -LIM, int'(off_cos) == -LIM);

        step(0.0);
        chk("R2", "corrected output mismatches", r2_bad, 0, r2_bad == 0);
        chk("R10", "correction moved without pulse", r10_bad, 0, r10_bad == 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule